// File: doc/BRIEF.md
# DMA Interrupt Status Controller

This block holds the interrupt and command registers of a descriptor-based Ethernet DMA engine. The engines send single-cycle event pulses, one wire per cause. Each pulse sets a sticky cause bit. The block derives two summary flags from the causes that are set and enabled: a normal flag for completion events and an abnormal flag for error and stall events. Either flag raises the interrupt line when its own enable bit is set.

Software uses a single-cycle register port with four word addresses:

| Address | Register |
|---------|----------|
| 0 | control |
| 1 | status |
| 2 | interrupt enable |
| 3 | transmit poll |

- Status bits are cleared by writing ones to them.
- The control register drives the run levels of the transmit and receive engines.
- Any write to the poll address sends a one-cycle kick to the transmit engine so that it re-reads its descriptor.
- The status word also carries the live process states of both engines.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, the control word, the interrupt-enable word and all status cause bits read zero. `irq`, `tx_run`, `rx_run` and `tx_poll` are low.
- R2: The cause positions are split into two groups.
  - Normal causes: bit 0 (transmit done) and bit 5 (receive done).
  - Abnormal causes: bit 1 (transmit stopped), bit 2 (transmit jabber), bit 3 (receive overflow), bit 4 (transmit underflow), bit 6 (receive buffer unavailable), bit 7 (receive stopped), bit 8 (receive watchdog timeout), bit 9 (early transmit) and bit 13 (fatal bus error).
  - A pulse on `evt[i]` at a clock edge sets status bit i from that edge on, and the bit stays set until software clears it.
  - Pulses at any other `evt` position are ignored, and those status bits read 0.
- R3: A write to the status address clears each cause bit whose `wdata` bit is 1. A `wdata` bit of 0 leaves the matching cause bit unchanged.
- R4: When an event pulse and a write-one clear hit the same cause bit at the same edge, the bit ends up set.
- R5: Status bit 15 (abnormal summary) reads 1 exactly when some abnormal cause bit is set and its interrupt-enable bit (same position) is 1.
- R6: Status bit 16 (normal summary) reads 1 exactly when bit 0 or bit 5 is set together with its interrupt-enable bit.
- R7: `irq` equals (enable bit 15 AND status bit 15) OR (enable bit 16 AND status bit 16). An all-zero enable word keeps `irq` low. Enable bits at positions that are neither a cause nor a summary read 0.
- R8: Any write to the poll address raises `tx_poll` for exactly the one cycle after the write edge. `tx_poll` is never high otherwise, and the poll address reads 0.
- R9: The control word reads back exactly as written in all 32 bits. Bit 1 drives `tx_run` and bit 0 drives `rx_run`.
- R10: Status bits 19:17 show `rx_state` and bits 22:20 show `tx_state` live. Writes have no effect on these bits, and the other upper status bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address: 0 control, 1 status, 2 enable, 3 poll |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| evt | input | 17 | Per-cause event pulses from the DMA engines |
| tx_state | input | 3 | Current transmit process state |
| rx_state | input | 3 | Current receive process state |
| irq | output | 1 | Interrupt request |
| tx_run | output | 1 | Transmit engine run level |
| rx_run | output | 1 | Receive engine run level |
| tx_poll | output | 1 | One-cycle transmit poll kick |

## Verification
Register state and the poll pulse change at the edge that samples a write or an event. The read port, the summary bits and `irq` are combinational from that state, so every result is due one edge after its stimulus. The one exception is the process-state fields, which follow their inputs in the same cycle.

The bench drives inputs 2 ns after a rising edge. Its reference model steps at each edge from the inputs that stood across that edge. All outputs are compared 1 ns after the edge, and directed reads take place in the low phase after the expected edge, before the next one.

// File: rtl/dma_irq_regs.sv
module dma_irq_regs #(
  parameter int DW = 32,
  parameter int AW = 2,
  parameter int SW = 3,
  parameter int NC = 17,
  parameter logic [NC-1:0] NORM_MASK = 17'h00021,
  parameter logic [NC-1:0] ABN_MASK  = 17'h023DE,
  parameter int ABN_BIT = 15,
  parameter int NORM_BIT = 16,
  parameter int RX_ST_LSB = 17,
  parameter int TX_ST_LSB = 20,
  parameter int RX_RUN_BIT = 0,
  parameter int TX_RUN_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NC-1:0] evt,
  input  logic [SW-1:0] tx_state,
  input  logic [SW-1:0] rx_state,
  output logic          irq,
  output logic          tx_run,
  output logic          rx_run,
  output logic          tx_poll
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_IEN  = AW'(2);
  localparam logic [AW-1:0] A_POLL = AW'(3);
  localparam logic [NC-1:0] CAUSE_MASK = NORM_MASK | ABN_MASK;
  localparam logic [NC-1:0] SUM_MASK = (NC'(1) << ABN_BIT) | (NC'(1) << NORM_BIT);
  localparam logic [NC-1:0] EN_MASK = CAUSE_MASK | SUM_MASK;

  logic [NC-1:0] cause_q, en_q, clr, act;
  logic [DW-1:0] ctrl_q, stat_w;
  logic          poll_q, abn_sum, norm_sum;

  assign clr      = (wr_en && addr == A_STAT) ? wdata[NC-1:0] : '0;
  assign act      = cause_q & en_q;
  assign abn_sum  = |(act & ABN_MASK);
  assign norm_sum = |(act & NORM_MASK);
  assign irq      = (en_q[ABN_BIT] & abn_sum) | (en_q[NORM_BIT] & norm_sum);
  assign tx_run   = ctrl_q[TX_RUN_BIT];
  assign rx_run   = ctrl_q[RX_RUN_BIT];
  assign tx_poll  = poll_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      en_q    <= '0;
      ctrl_q  <= '0;
      poll_q  <= 1'b0;
    end else begin
      cause_q <= ((cause_q & ~clr) | evt) & CAUSE_MASK;
      poll_q  <= wr_en && addr == A_POLL;
      if (wr_en && addr == A_IEN)  en_q   <= wdata[NC-1:0] & EN_MASK;
      if (wr_en && addr == A_CTRL) ctrl_q <= wdata;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[NC-1:0] = cause_q;
    stat_w[ABN_BIT] = abn_sum;
    stat_w[NORM_BIT] = norm_sum;
    stat_w[RX_ST_LSB +: SW] = rx_state;
    stat_w[TX_ST_LSB +: SW] = tx_state;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_STAT:  rdata = stat_w;
      A_IEN:   rdata = DW'(en_q);
      default: rdata = '0;
    endcase
  end
endmodule

module dma_irq_regs_chk #(
  parameter int AW = 2,
  parameter int DW = 32,
  parameter int NC = 17,
  parameter logic [NC-1:0] NORM_MASK = 17'h00021,
  parameter logic [NC-1:0] ABN_MASK  = 17'h023DE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [NC-1:0] evt,
  input logic [NC-1:0] cause_q,
  input logic [NC-1:0] en_q,
  input logic          irq,
  input logic          tx_poll
);
  localparam logic [NC-1:0] CAUSE_MASK = NORM_MASK | ABN_MASK;
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_POLL = AW'(3);

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_STAT) |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT) |=> ((cause_q & $past(wdata[NC-1:0] & ~evt)) == '0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & CAUSE_MASK)) |=> ((cause_q & $past(evt & CAUSE_MASK)) == $past(evt & CAUSE_MASK))); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq); // R7
  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(cause_q & en_q))); // R7
  AST_POLL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_POLL) |=> tx_poll); // R8
  AST_POLL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |-> $past(wr_en && addr == A_POLL)); // R8
endmodule

bind dma_irq_regs dma_irq_regs_chk #(
  .AW(AW), .DW(DW), .NC(NC), .NORM_MASK(NORM_MASK), .ABN_MASK(ABN_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .evt(evt), .cause_q(cause_q), .en_q(en_q), .irq(irq), .tx_poll(tx_poll)
);

// File: tb/dma_irq_regs_bench.sv
`timescale 1ns/1ps
module dma_irq_regs_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [16:0] evt = '0;
  logic [2:0]  tx_state = '0, rx_state = '0;
  logic        irq, tx_run, rx_run, tx_poll;

  dma_irq_regs u_dma_irq_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt(evt), .tx_state(tx_state), .rx_state(rx_state),
    .irq(irq), .tx_run(tx_run), .rx_run(rx_run), .tx_poll(tx_poll)
  );

  int n_tests = 0, n_fail = 0;
  bit [16:0] m_cause, m_en;
  bit [31:0] m_ctrl;
  bit        m_poll;

  function automatic bit is_norm(int i);
    return i == 0 || i == 5;
  endfunction
  function automatic bit is_abn(int i);
    case (i)
      1, 2, 3, 4, 6, 7, 8, 9, 13: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
  function automatic bit m_abn();
    for (int i = 0; i < 17; i++) if (is_abn(i) && m_cause[i] && m_en[i]) return 1'b1;
    return 1'b0;
  endfunction
  function automatic bit m_norm();
    for (int i = 0; i < 17; i++) if (is_norm(i) && m_cause[i] && m_en[i]) return 1'b1;
    return 1'b0;
  endfunction
  function automatic bit m_irq();
    return (m_en[15] && m_abn()) || (m_en[16] && m_norm());
  endfunction
  function automatic logic [31:0] m_read(logic [1:0] a);
    logic [31:0] s;
    case (a)
      2'd0: return m_ctrl;
      2'd1: begin
        s = 32'(m_cause);
        s[15] = m_abn();
        s[16] = m_norm();
        s[19:17] = rx_state;
        s[22:20] = tx_state;
        return s;
      end
      2'd2: return 32'(m_en);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cause = '0; m_en = '0; m_ctrl = '0; m_poll = 1'b0;
    end else begin
      m_poll = wr_en && addr == 2'd3;
      for (int i = 0; i < 17; i++) begin
        if (is_norm(i) || is_abn(i)) begin
          if (evt[i]) m_cause[i] = 1'b1;
          else if (wr_en && addr == 2'd1 && wdata[i]) m_cause[i] = 1'b0;
        end
      end
      if (wr_en && addr == 2'd2)
        for (int i = 0; i < 17; i++)
          m_en[i] = (is_norm(i) || is_abn(i) || i == 15 || i == 16) ? wdata[i] : 1'b0;
      if (wr_en && addr == 2'd0) m_ctrl = wdata;
    end
    #1;
    if (rst_n) begin
      chk("R2 R3 R4 R5 R6 R10 model rdata", rdata, m_read(addr));
      chk("R7 model irq", 32'(irq), 32'(m_irq()));
      chk("R8 model poll", 32'(tx_poll), 32'(m_poll));
      chk("R9 model run", {30'h0, tx_run, rx_run}, {30'h0, m_ctrl[1], m_ctrl[0]});
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    logic [1:0] keep;
    keep = addr;
    addr = a;
    #0.5;
    v = rdata;
    addr = keep;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc();
    wr_en = 1'b0; wdata = '0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    rd(2'd0, v); chk("R1 ctrl after reset", v, 32'h0);
    rd(2'd1, v); chk("R1 status after reset", v, 32'h0);
    rd(2'd2, v); chk("R1 enable after reset", v, 32'h0);
    chk("R1 outputs after reset", {28'h0, irq, tx_run, rx_run, tx_poll}, 32'h0);

    evt = 17'h04020; cyc(); evt = '0;
    rd(2'd1, v); chk("R2 receive-done set, reserved ignored", v, 32'h20);
    repeat (3) cyc();
    rd(2'd1, v); chk("R2 cause stays set", v, 32'h20);

    tx_state = 3'b101; rx_state = 3'b010;
    wr(2'd1, 32'h007E_0000);
    rd(2'd1, v); chk("R10 live states, write ignored", v, 32'h0054_0020);
    tx_state = '0; rx_state = '0;

    wr(2'd1, 32'h0000_0001);
    rd(2'd1, v); chk("R3 write zero keeps bit", v, 32'h20);
    wr(2'd1, 32'h0000_0020);
    rd(2'd1, v); chk("R3 write one clears bit", v, 32'h0);

    evt = 17'h02000; wr_en = 1'b1; addr = 2'd1; wdata = 32'h2000;
    cyc(); evt = '0; wr_en = 1'b0; wdata = '0;
    rd(2'd1, v); chk("R4 set beats clear", v, 32'h2000);
    wr(2'd1, 32'h2000);

    evt = 17'h00010; cyc(); evt = '0;
    rd(2'd1, v); chk("R5 no summary while disabled", v, 32'h10);
    chk("R7 irq masked by zero enable", 32'(irq), 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R7 enable unused bits read zero", v, 32'h0001_A3FF);
    wr(2'd2, 32'h0000_8010);
    rd(2'd1, v); chk("R5 abnormal summary", v, 32'h8010);
    chk("R7 irq from abnormal", 32'(irq), 32'h1);
    wr(2'd2, 32'h0000_0010);
    chk("R7 irq gated by summary enable", 32'(irq), 32'h0);
    wr(2'd2, 32'h0001_0001);
    evt = 17'h00001; cyc(); evt = '0;
    rd(2'd1, v); chk("R6 normal summary only", v, 32'h0001_0011);
    chk("R7 irq from normal", 32'(irq), 32'h1);
    wr(2'd1, 32'h0001_FFFF);
    chk("R7 irq drops after clear", 32'(irq), 32'h0);

    wr(2'd3, 32'h0);
    chk("R8 poll pulse", 32'(tx_poll), 32'h1);
    cyc();
    chk("R8 poll one cycle", 32'(tx_poll), 32'h0);
    rd(2'd3, v); chk("R8 poll reads zero", v, 32'h0);

    wr(2'd0, 32'hA5A5_5A5B);
    rd(2'd0, v); chk("R9 ctrl readback", v, 32'hA5A5_5A5B);
    chk("R9 both run", {30'h0, tx_run, rx_run}, 32'h3);
    wr(2'd0, 32'hFFFF_FFFD);
    chk("R9 tx stops, rx runs", {30'h0, tx_run, rx_run}, 32'h1);

    for (int k = 0; k < 4000; k++) begin
      wr_en = ($urandom % 3) == 0;
      addr = 2'($urandom);
      wdata = (($urandom % 2) == 0) ? $urandom : ($urandom & $urandom);
      evt = 17'($urandom & $urandom & $urandom);
      if (($urandom % 8) == 0) begin
        tx_state = 3'($urandom);
        rx_state = 3'($urandom);
      end
      cyc();
    end
    wr_en = 1'b0; evt = '0;
    cyc();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule